// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is a register-programmed SPI master. Software writes a transmit word, a clock divider and a shift command, and the block then clocks out between 1 and 32 bits on the serial bus while it captures the same number of bits from the slave. Each command carries three things: the bit count, which chip selects to drive, and whether chip select is released once the last bit is done. Chip select can therefore stay low across several commands, so one long transaction can be built from many short ones without any buffering.

The serial bus runs in mode 0. SCK idles low, the master changes MOSI while SCK is low, and it samples MISO on the rising SCK edge. The half period of SCK is (d+1) system clocks, where d is the divider field. A busy flag in the command register reads high for the whole shift and clears itself after the last falling SCK edge. Software polls that flag.

The register bus is plain control and is not a stream. A write is accepted in the cycle it is presented, with no back-pressure and no ready signal. Read data is combinational from the address and shows live state.

Top module: `spi_shift_master`

## Requirements
- R1: After reset every register reads 0, except pin-control (offset 0x08), which reads 0x00070000. The pins are then SCK=0, MOSI=0 and cs_n=3'b111.
- R2: While bit 0 of function-select (offset 0x00) is 0, writes to every other offset are ignored and read back unchanged. A shift command starts nothing, and the pins stay at SCK=0, MOSI=0, cs_n=3'b111.
- R3: The divider d is held in clock-control bits [5:0] (offset 0x04). A command of n bits keeps busy high for exactly 2*(d+1)*n system cycles and produces exactly n rising SCK edges.
- R4: MOSI carries data-out (offset 0x10) bits [n-1:0], most significant bit first. MOSI changes only while SCK is low.
- R5: After a command of n bits, data-in (offset 0x18) holds the received bits in bits [n-1:0], with the last bit received in bit 0 and all higher bits 0.
- R6: Writing shift-control (offset 0x14) with bit 31 set and a nonzero count starts a shift. Bit 31 reads 1 while shifting and returns to 0 by itself.
- R7: Shift-control bits [30:28] pick chip selects 2..0. Every picked cs_n line is low for the whole shift.
- R8: With shift-control bit 26 set, the picked chip selects go high after the last bit. With bit 26 clear, they stay low after busy clears and remain low until the next command.
- R9: A write to shift-control while busy is ignored. The fields read back unchanged and the running shift keeps its full length.
- R10: The count is held in shift-control bits [5:0]. A count of 0 with bit 31 set leaves busy clear and toggles no SCK. A count above 32 shifts 32 bits.
- R11: While enabled and idle, pin-control bits [18:16] drive cs_n[2:0], bit 1 drives SCK and bit 0 drives MOSI.
- R12: Clock-control, data-out and the shift-control fields read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Live read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
A shift command written at clock edge E0 sets busy at E0 itself. The first rising SCK edge is due at E0+(d+1) and busy falls at E0+2(d+1)n, so the bench polls the busy bit on every falling clock edge after the write and requires exactly 2(d+1)n high samples. Register writes and pin-control changes are visible at the first falling edge after their write edge, so the bench reads them back then. Data-in, the bits the slave model captured and the chip-select level after the command are checked only once busy is seen low.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 32;
  localparam int NCS    = 3;
  localparam int DIV_W  = 6;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  localparam logic [ADDR_W-1:0] OFF_FSEL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CLK   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PIN   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_DOUT  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_SHIFT = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_DIN   = 5'h18;

  localparam int GO_BIT     = 31;
  localparam int SEL_LSB    = 28;
  localparam int TERM_BIT   = 26;
  localparam int PIN_CS_LSB = 16;
  localparam int PIN_SCK    = 1;
  localparam int PIN_MOSI   = 0;

  typedef struct packed {
    logic [NCS-1:0]   sel;
    logic             term;
    logic [CNT_W-1:0] cnt;
  } shift_cmd_t;

  typedef struct packed {
    logic [NCS-1:0] cs;
    logic           sck;
    logic           mosi;
  } pin_cfg_t;
endpackage

// File: rtl/sck_div_tick.sv
module sck_div_tick #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_o
);
  logic              busy_q, sck_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] tx_sr, rx_sr;
  logic [CNT_W:0]    shamt;

  assign shamt  = (CNT_W+1)'(WORD_W) - {1'b0, count_i};
  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = tx_sr[WORD_W-1];
  assign rx_o   = rx_sr;
  assign done_o = busy_q && tick_i && sck_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      left_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      left_q <= count_i;
      tx_sr  <= tx_i << shamt;
      rx_sr  <= '0;
    end else if (busy_q && tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_sr <= {rx_sr[WORD_W-2:0], miso_i};
      end else begin
        sck_q  <= 1'b0;
        tx_sr  <= tx_sr << 1;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  // R3
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i) |=> $stable(sck_q));
  // R4
  mosi_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sck_q) |=> $stable(mosi_o));
  // R6
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> !sck_q);
endmodule

// File: rtl/cs_hold_ctl.sv
module cs_hold_ctl #(
  parameter int NCS = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NCS-1:0] sel_i,
  input  logic           release_i,
  output logic [NCS-1:0] active_o
);
  logic [NCS-1:0] act_q;
  assign active_o = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_q <= '0;
    else if (start_i)    act_q <= sel_i;
    else if (release_i)  act_q <= '0;
  end

  // R8
  cs_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !release_i) |=> $stable(act_q));
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W,
  parameter int NC = NCS,
  parameter int DVW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [NC-1:0] spi_cs_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DW);

  logic           en_q;
  logic [DVW-1:0] div_q;
  pin_cfg_t       pin_q;
  logic [DW-1:0]  dout_q;
  shift_cmd_t     cmd_q;

  logic           wr, fsel_wr, clk_wr, pin_wr, dout_wr, shift_wr;
  logic [CNT_W-1:0] wr_cnt, eff_cnt;
  logic           start;
  logic           eng_busy, eng_sck, eng_mosi, eng_done, tick;
  logic [DW-1:0]  eng_rx;
  logic [NC-1:0]  cs_act;

  assign wr       = bus_en && bus_we;
  assign fsel_wr  = wr && (bus_addr == OFF_FSEL);
  assign clk_wr   = wr && en_q && (bus_addr == OFF_CLK);
  assign pin_wr   = wr && en_q && (bus_addr == OFF_PIN);
  assign dout_wr  = wr && en_q && (bus_addr == OFF_DOUT);
  assign shift_wr = wr && en_q && (bus_addr == OFF_SHIFT);

  assign wr_cnt  = bus_wdata[CNT_W-1:0];
  assign eff_cnt = (wr_cnt > CNT_MAX) ? CNT_MAX : wr_cnt;
  assign start   = shift_wr && !eng_busy && bus_wdata[GO_BIT] && (wr_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      pin_q  <= '{cs: '1, sck: 1'b0, mosi: 1'b0};
      dout_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (fsel_wr) en_q   <= bus_wdata[0];
      if (clk_wr)  div_q  <= bus_wdata[DVW-1:0];
      if (pin_wr)  pin_q  <= '{cs:   bus_wdata[PIN_CS_LSB +: NC],
                               sck:  bus_wdata[PIN_SCK],
                               mosi: bus_wdata[PIN_MOSI]};
      if (dout_wr) dout_q <= bus_wdata;
      if (shift_wr && !eng_busy)
        cmd_q <= '{sel:  bus_wdata[SEL_LSB +: NC],
                   term: bus_wdata[TERM_BIT],
                   cnt:  wr_cnt};
    end
  end

  sck_div_tick #(.DIV_W(DVW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (eng_busy),
    .div_i (div_q),
    .tick_o(tick)
  );

  spi_bit_engine #(.WORD_W(DW), .CNT_W(CNT_W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .count_i(eff_cnt),
    .tx_i   (dout_q),
    .tick_i (tick),
    .miso_i (spi_miso),
    .busy_o (eng_busy),
    .sck_o  (eng_sck),
    .mosi_o (eng_mosi),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  cs_hold_ctl #(.NCS(NC)) u_cs (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .sel_i    (bus_wdata[SEL_LSB +: NC]),
    .release_i(eng_done && cmd_q.term),
    .active_o (cs_act)
  );

  assign spi_sck  = en_q && (eng_busy ? eng_sck  : pin_q.sck);
  assign spi_mosi = en_q && (eng_busy ? eng_mosi : pin_q.mosi);
  assign spi_cs_n = en_q ? (pin_q.cs & ~cs_act) : '1;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_FSEL:  bus_rdata[0] = en_q;
      OFF_CLK:   bus_rdata[DVW-1:0] = div_q;
      OFF_PIN: begin
        bus_rdata[PIN_CS_LSB +: NC] = pin_q.cs;
        bus_rdata[PIN_SCK]          = pin_q.sck;
        bus_rdata[PIN_MOSI]         = pin_q.mosi;
      end
      OFF_DOUT:  bus_rdata = dout_q;
      OFF_SHIFT: begin
        bus_rdata[GO_BIT]           = eng_busy;
        bus_rdata[SEL_LSB +: NC]    = cmd_q.sel;
        bus_rdata[TERM_BIT]         = cmd_q.term;
        bus_rdata[CNT_W-1:0]        = cmd_q.cnt;
      end
      OFF_DIN:   bus_rdata = eng_rx;
      default:   bus_rdata = '0;
    endcase
  end

  // R7
  cs_during_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && en_q) |-> ((~spi_cs_n & cmd_q.sel) == cmd_q.sel));
  // R8
  term_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eng_busy) && cmd_q.term) |-> (cs_act == '0));
  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && shift_wr) |=> ($stable(cmd_q) && eng_busy));
  // R10
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr && !eng_busy && (wr_cnt == '0)) |=> (!eng_busy && !spi_sck));
  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (spi_cs_n == '1 && !spi_sck && !spi_mosi));
endmodule

// File: tb/spi_shift_master_bench.sv
module spi_shift_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;

  int errs = 0;
  int checks = 0;
  int sck_rises = 0;
  logic [31:0] slv_rx = '0;
  logic [31:0] slv_tx = '0;

  always #10 clk = ~clk;

  spi_shift_master u_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  assign spi_miso = slv_tx[31];
  always @(posedge spi_sck) begin
    sck_rises = sck_rises + 1;
    slv_rx = {slv_rx[30:0], spi_mosi};
  end
  always @(negedge spi_sck) slv_tx = slv_tx << 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] nmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic logic [31:0] shcmd(input logic [2:0] sel, input bit term,
                                        input logic [5:0] cnt);
    return {1'b1, sel, 1'b0, term, 20'b0, cnt};
  endfunction

  task automatic run_cmd(input int d, input logic [5:0] raw, input logic [2:0] sel,
                         input bit term, input logic [31:0] dout, input logic [31:0] pat,
                         input logic [31:0] stray);
    int n, cyc;
    logic [31:0] v;
    logic [2:0] cs_mid;
    n = (raw > 6'd32) ? 32 : int'(raw);
    wr(5'h04, 32'(d));
    wr(5'h10, dout);
    slv_tx = pat << (32 - n);
    slv_rx = '0;
    sck_rises = 0;
    wr(5'h14, shcmd(sel, term, raw));
    bus_addr = 5'h14;
    #1 cs_mid = spi_cs_n;
    cyc = 0;
    while (cyc < 20000) begin
      if (!bus_rdata[31]) break;
      cyc++;
      if (stray != 0 && cyc == 3) begin
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_wdata = stray;
        #1 if (bus_rdata[31]) cyc++;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        #1;
        continue;
      end
      @(negedge clk);
      #1;
    end
    check(cyc == 2*(d+1)*n, "R3 busy cycles", cyc, 2*(d+1)*n);
    check(sck_rises == n, "R3 sck rises", sck_rises, n);
    check((slv_rx & nmask(n)) == (dout & nmask(n)), "R4 mosi bits",
          slv_rx & nmask(n), dout & nmask(n));
    check(cs_mid == ~sel, "R7 cs during shift", cs_mid, ~sel);
    rd(5'h18, v);
    check(v == (pat & nmask(n)), "R5 data-in", v, pat & nmask(n));
    check(spi_cs_n == (term ? 3'b111 : ~sel), "R8 cs after", spi_cs_n,
          term ? 3'b111 : ~sel);
    rd(5'h14, v);
    check(v == (shcmd(sel, term, raw) & 32'h7FFF_FFFF), "R12 shift fields", v,
          shcmd(sel, term, raw) & 32'h7FFF_FFFF);
  endtask

  initial begin
    #(200000 * 20);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, v); check(v == 0, "R1 fsel", v, 0);
    rd(5'h04, v); check(v == 0, "R1 clk", v, 0);
    rd(5'h08, v); check(v == 32'h0007_0000, "R1 pin", v, 32'h0007_0000);
    rd(5'h14, v); check(v == 0, "R1 shift", v, 0);
    rd(5'h18, v); check(v == 0, "R1 din", v, 0);
    check({spi_cs_n, spi_sck, spi_mosi} == 5'b11100, "R1 pins",
          {spi_cs_n, spi_sck, spi_mosi}, 5'b11100);

    // R2 disabled: writes ignored, no shift
    sck_rises = 0;
    wr(5'h04, 32'd5);
    wr(5'h08, 32'h0000_0003);
    wr(5'h14, shcmd(3'b001, 1'b1, 6'd8));
    rd(5'h04, v); check(v == 0, "R2 clk write ignored", v, 0);
    rd(5'h14, v); check(v == 0, "R2 shift write ignored", v, 0);
    repeat (20) @(negedge clk);
    check(sck_rises == 0, "R2 no sck", sck_rises, 0);
    check({spi_cs_n, spi_sck, spi_mosi} == 5'b11100, "R2 pins idle",
          {spi_cs_n, spi_sck, spi_mosi}, 5'b11100);

    wr(5'h00, 32'h1);
    // R11 pin-control drives idle pins
    wr(5'h08, 32'h0005_0003);
    #1 check({spi_cs_n, spi_sck, spi_mosi} == 5'b10111, "R11 pin drive",
             {spi_cs_n, spi_sck, spi_mosi}, 5'b10111);
    wr(5'h08, 32'h0007_0000);
    #1 check({spi_cs_n, spi_sck, spi_mosi} == 5'b11100, "R11 pin restore",
             {spi_cs_n, spi_sck, spi_mosi}, 5'b11100);

    // R12 readback
    wr(5'h10, 32'hA5C3_0F96);
    rd(5'h10, v); check(v == 32'hA5C3_0F96, "R12 dout", v, 32'hA5C3_0F96);

    // R6 directed shift, busy self-clears
    run_cmd(0, 6'd8, 3'b001, 1'b1, 32'h0000_00B4, 32'h0000_0069, 0);
    rd(5'h14, v); check(v[31] == 1'b0, "R6 busy clear", v[31], 0);

    // R8 hold then release
    run_cmd(1, 6'd16, 3'b010, 1'b0, 32'h0000_1234, 32'h0000_ABCD, 0);
    repeat (5) @(negedge clk);
    check(spi_cs_n == 3'b101, "R8 cs held", spi_cs_n, 3'b101);
    run_cmd(1, 6'd1, 3'b010, 1'b1, 32'h1, 32'h1, 0);

    // R10 zero count, over-range count
    sck_rises = 0;
    wr(5'h14, shcmd(3'b100, 1'b1, 6'd0));
    bus_addr = 5'h14;
    #1 check(bus_rdata[31] == 1'b0, "R10 zero count idle", bus_rdata[31], 0);
    repeat (10) @(negedge clk);
    check(sck_rises == 0, "R10 zero count no sck", sck_rises, 0);
    run_cmd(0, 6'd40, 3'b100, 1'b1, 32'hDEAD_BEEF, 32'h1357_9BDF, 0);

    // R9 write while busy ignored
    run_cmd(3, 6'd32, 3'b001, 1'b1, 32'hCAFE_F00D, 32'h0F0F_3C3C,
            shcmd(3'b100, 1'b0, 6'd4));

    // random commands
    for (int i = 0; i < 25; i++) begin
      int d;
      logic [5:0] n;
      logic [2:0] sel;
      bit term;
      d = int'($urandom_range(0, 3));
      n = 6'($urandom_range(1, 32));
      sel = 3'b001 << $urandom_range(0, 2);
      term = (i == 24) ? 1'b1 : 1'($urandom_range(0, 1));
      run_cmd(d, n, sel, term, $urandom, $urandom, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule